// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous SRAM model that can be synthesized. It removes the idle bus cycles that normally separate a read from a following write. A write command is registered with its address, but its data is taken from the bus later. The delay equals the read latency of the selected mode. Because of this, a command stream can mix reads and writes in any order and the shared data bus never needs a dead cycle to turn around.

The static mode input selects one of two modes. Pipelined mode has two cycles of latency and flow-through mode has one. Commands come in two kinds. A load samples the address, the three chip selects and the read/write direction. An advance steps a 2-bit burst counter, in interleaved or linear order. A clock-enable style stall input freezes the whole block. The data bus is a tri-state bus, split into an input port, an output port and a drive-enable port. The drive is gated by an asynchronous output enable and by a snooze input.

A read can target a word whose write data is still in the write pipeline. In that case the read returns the pending bytes merged over the stored word.

Top module: `late_write_sram`

## Requirements
- R1: With `pipe_mode`=1, a read loaded at clock edge N drives its word on `dq_out` from edge N+2 until the next unstalled edge.
- R2: With `pipe_mode`=0, a read loaded at edge N drives its word from edge N+1.
- R3: The data of a write loaded at edge N is sampled from `dq_in` at edge N+2 in pipelined mode and at edge N+1 in flow-through mode.
- R4: With `adv`=0, a new command is loaded. The block is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. In that case `rnw`=1 starts a read and `rnw`=0 starts a write. Any other select combination is a deselect, and the bus is not driven in the cycle where a read's result would have been due.
- R5: With `adv`=1, `addr`, the selects and `rnw` are ignored and the burst continues with the operation type it was loaded with. A burst that follows a deselect stays a deselect.
- R6: Let S be the two low address bits loaded with the burst, and k = 1, 2, 3, 4, ... the advance count taken modulo 4. With `burst_ilv`=1, advance k uses S XOR k. With `burst_ilv`=0, it uses (S + k) mod 4. The upper address bits stay fixed for the whole burst.
- R7: While `stall`=1, no command is sampled, no write data is taken, the burst counter holds and the bus keeps showing what it showed before the stall.
- R8: `bw_n[b]` is active low, controls `dq` bits [8b+7:8b] and is sampled with every write command and every burst write. A byte whose enable is 1 keeps its stored value.
- R9: `oe_n`=1 turns `dq_oe` off immediately, without waiting for a clock edge. Writes never need `oe_n` to be high.
- R10: `snooze`=1 keeps `dq_oe` low. Stored contents are retained and can be read once `snooze` returns to 0.
- R11: A read whose address matches a write with data still pending returns that write's enabled bytes merged over the stored word.
- R12: After reset the bus is not driven and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the control pipeline |
| stall | input | 1 | High freezes the whole block for the cycle |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 advances the burst, 0 loads a new command |
| rnw | input | 1 | On load: 1 read, 0 write |
| addr | input | ADDR_W | Word address, sampled on load |
| bw_n | input | NUM_BYTES | Byte write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 1 pipelined (latency 2), 0 flow-through (latency 1) |
| burst_ilv | input | 1 | 1 interleaved burst order, 0 linear |
| snooze | input | 1 | High: low-power hold, outputs not driven |
| dq_in | input | NUM_BYTES*BYTE_W | Write data from the bus |
| dq_out | output | NUM_BYTES*BYTE_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Pipelined-mode results are due two unstalled edges after their command, and flow-through results one edge after. Write data is due on the bus at the same distance. The bench counts only the edges where `stall` is low, and it is at those edges that it takes write data and releases an expected bus value. Each expected item carries the number of the edge after which it must be visible. The monitor samples a quarter period after that edge, well away from any input change. The test for the asynchronous output enable toggles `oe_n` in the middle of a cycle and samples one time unit later, with no clock edge in between.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Width of the wrapping burst field at the bottom of the address.
  localparam int BURST_W = 2;

  // Address bits for burst step idx, starting from start.
  function automatic logic [BURST_W-1:0] burst_step(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] idx,
    input logic               ilv
  );
    return ilv ? (start ^ idx) : (start + idx);
  endfunction

endpackage

// File: rtl/lwsram_burst.sv
module lwsram_burst
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ilv,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);

  op_e               kind_q;
  logic [ADDR_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + 1'b1;

  // Command seen by the pipeline this cycle.
  always_comb begin
    if (!adv) begin
      cmd_op   = sel_ok ? (rnw ? OP_READ : OP_WRITE) : OP_IDLE;
      cmd_addr = addr;
    end else begin
      cmd_op   = kind_q;
      cmd_addr = {base_q[ADDR_W-1:BURST_W], burst_step(base_q[BURST_W-1:0], cnt_nx, ilv)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (!hold) begin
      if (!adv) begin
        kind_q <= cmd_op;
        base_q <= addr;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end

  AST_ADV_KEEPS_KIND: assert property (@(posedge clk) disable iff (rst) (!hold && adv) |=> $stable(kind_q)); // R5
  AST_ADV_KEEPS_BASE: assert property (@(posedge clk) disable iff (rst) (!hold && adv) |=> $stable(base_q)); // R6
  AST_HOLD_KEEPS_CNT: assert property (@(posedge clk) disable iff (rst) hold |=> $stable(cnt_q) && $stable(kind_q)); // R7

endmodule

// File: rtl/lwsram_pipe.sv
module lwsram_pipe
  import lwsram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hold,
  input  logic                 pipe_mode,
  input  op_e                  cmd_op,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [NUM_BYTES-1:0] cmd_ben,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [NUM_BYTES-1:0] wr_ben,
  output logic                 rd_en,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_due
);

  op_e                  op1_q, op2_q;
  logic                 rd3_q;
  logic [ADDR_W-1:0]    addr1_q, addr2_q;
  logic [NUM_BYTES-1:0] ben1_q, ben2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op1_q <= OP_IDLE;
      op2_q <= OP_IDLE;
      rd3_q <= 1'b0;
    end else if (!hold) begin
      op1_q <= cmd_op;
      op2_q <= op1_q;
      rd3_q <= (op2_q == OP_READ);
    end
  end

  // Datapath stages carry no reset.
  always_ff @(posedge clk) begin
    if (!hold) begin
      addr1_q <= cmd_addr;
      ben1_q  <= cmd_ben;
      addr2_q <= addr1_q;
      ben2_q  <= ben1_q;
    end
  end

  // Write commits at the stage matching read latency.
  assign wr_en   = pipe_mode ? (op2_q == OP_WRITE) : (op1_q == OP_WRITE);
  assign wr_addr = pipe_mode ? addr2_q : addr1_q;
  assign wr_ben  = pipe_mode ? ben2_q  : ben1_q;

  assign rd_en   = (op1_q == OP_READ);
  assign rd_addr = addr1_q;
  assign rd_due  = pipe_mode ? rd3_q : (op2_q == OP_READ);

  AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (rst) hold |=> $stable(op1_q) && $stable(op2_q) && $stable(rd3_q)); // R7

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int ADDR_W    = 10,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8,
  localparam int DATA_W   = NUM_BYTES * BYTE_W,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_BYTES-1:0] wr_ben,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_word
);

  logic                 hit_q;
  logic [DATA_W-1:0]    fwd_q;
  logic [NUM_BYTES-1:0] fwd_ben_q;

  // Same-edge write to the read address: the RAM returns old data, so keep the new bytes aside.
  always_ff @(posedge clk) begin
    if (en && rd_en) begin
      hit_q     <= wr_en && (wr_addr == rd_addr);
      fwd_q     <= wr_data;
      fwd_ben_q <= wr_ben;
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (en) begin
        if (wr_en && !wr_ben[g]) mem[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
        if (rd_en) q <= mem[rd_addr];
      end
    end

    assign rd_word[g*BYTE_W +: BYTE_W] = (hit_q && !fwd_ben_q[g]) ? fwd_q[g*BYTE_W +: BYTE_W] : q;
  end

endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import lwsram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stall,
  input  logic                 sel0_n,
  input  logic                 sel1,
  input  logic                 sel2_n,
  input  logic                 adv,
  input  logic                 rnw,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BYTES-1:0] bw_n,
  input  logic                 oe_n,
  input  logic                 pipe_mode,
  input  logic                 burst_ilv,
  input  logic                 snooze,
  input  logic [DATA_W-1:0]    dq_in,
  output logic [DATA_W-1:0]    dq_out,
  output logic                 dq_oe
);

  op_e                  cmd_op;
  logic [ADDR_W-1:0]    cmd_addr;
  logic                 wr_en, rd_en, rd_due;
  logic [ADDR_W-1:0]    wr_addr, rd_addr;
  logic [NUM_BYTES-1:0] wr_ben;
  logic [DATA_W-1:0]    rd_word;
  logic [DATA_W-1:0]    out_q;
  logic                 sel_ok;

  assign sel_ok = !sel0_n && sel1 && !sel2_n;

  lwsram_burst #(.ADDR_W(ADDR_W)) i_burst (
    .clk      (clk),
    .rst      (rst),
    .hold     (stall),
    .adv      (adv),
    .sel_ok   (sel_ok),
    .rnw      (rnw),
    .addr     (addr),
    .ilv      (burst_ilv),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr)
  );

  lwsram_pipe #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) i_pipe (
    .clk       (clk),
    .rst       (rst),
    .hold      (stall),
    .pipe_mode (pipe_mode),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_ben   (bw_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_ben    (wr_ben),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_due    (rd_due)
  );

  lwsram_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) i_array (
    .clk     (clk),
    .en      (!stall),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_ben  (wr_ben),
    .wr_data (dq_in),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_word (rd_word)
  );

  // Second read register for pipelined mode.
  always_ff @(posedge clk) begin
    if (!stall) out_q <= rd_word;
  end

  assign dq_out = pipe_mode ? out_q : rd_word;
  assign dq_oe  = rd_due && !oe_n && !snooze;

  AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (rst) oe_n |-> !dq_oe); // R9
  AST_SNOOZE_QUIET: assert property (@(posedge clk) disable iff (rst) snooze |-> !dq_oe); // R10
  AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && dq_oe && !$past(stall) && !$past(stall, 2)) |-> ($past(cmd_op, 2) == OP_READ)); // R2
  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && dq_oe && !$past(stall) && !$past(stall, 2) && !$past(stall, 3)) |-> ($past(cmd_op, 3) == OP_READ)); // R1

endmodule

// File: tb/test_late_write_sram.sv
module test_late_write_sram;

  localparam int PERIOD = 20;
  localparam int AW     = 10;
  localparam int NB     = 4;
  localparam int BW     = 8;
  localparam int DW     = NB * BW;
  localparam int DEPTH  = 1 << AW;

  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_RD   = 2'd1;
  localparam logic [1:0] K_WR   = 2'd2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall = 1'b0;
  logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic          adv = 1'b0, rnw = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bw_n = '1;
  logic          oe_n = 1'b0, pipe_mode = 1'b1, burst_ilv = 1'b1, snooze = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  late_write_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW)) i_late_write_sram (
    .clk(clk), .rst(rst), .stall(stall), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .adv(adv), .rnw(rnw), .addr(addr), .bw_n(bw_n), .oe_n(oe_n), .pipe_mode(pipe_mode),
    .burst_ilv(burst_ilv), .snooze(snooze), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    int            tag;
    logic          oe;
    logic [DW-1:0] data;
    string         req;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  int    edge_cnt = 0;
  string cur_req = "R12";

  // Reference state
  logic [DW-1:0] ref_mem [DEPTH];
  logic [1:0]    h_kind [8];
  logic [AW-1:0] h_addr [8];
  logic [NB-1:0] h_ben  [8];
  int            act = 0;
  int            lat = 2;
  int            bad_ix = 0;
  logic [1:0]    m_kind = K_NONE;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_vis = 1'b0;
  logic [DW-1:0] m_data = '0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [DW:0] actual, input logic [DW:0] expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual oe/data %h expected %h", req, actual, expected);
    end
  endtask

  // Monitor: pops items due after the latest edge
  always begin
    item_t it;
    @(posedge clk);
    #(PERIOD/4);
    while (sb.size() > 0 && sb[0].tag <= edge_cnt) begin
      it = sb.pop_front();
      if (it.oe)
        chk(dq_oe === 1'b1 && dq_out === it.data, it.req, {dq_oe, dq_out}, {1'b1, it.data});
      else
        chk(dq_oe === 1'b0, it.req, {dq_oe, dq_out}, {1'b0, it.data});
    end
  end

  task automatic model_clear();
    act = 0; m_kind = K_NONE; m_cnt = '0; m_vis = 1'b0;
    for (int i = 0; i < 8; i++) h_kind[i] = K_NONE;
  endtask

  // One clock: drive a command, update the model, queue the expected bus state
  task automatic step(input logic ld, input logic rd, input logic [AW-1:0] a,
                      input logic [NB-1:0] ben, input logic ok, input logic stl);
    int            src;
    logic [DW-1:0] wd;
    item_t         it;
    @(negedge clk);
    wd    = $urandom;
    dq_in = wd;
    stall = stl;
    bw_n  = ben;
    adv   = !ld;
    if (ld) begin
      rnw  = rd;
      addr = a;
      if (ok) {sel0_n, sel1, sel2_n} = 3'b010;
      else begin
        case (bad_ix % 3)
          0:       {sel0_n, sel1, sel2_n} = 3'b110;
          1:       {sel0_n, sel1, sel2_n} = 3'b000;
          default: {sel0_n, sel1, sel2_n} = 3'b011;
        endcase
        bad_ix++;
      end
    end else begin
      rnw  = 1'($urandom);
      addr = AW'($urandom);
      {sel0_n, sel1, sel2_n} = 3'($urandom);
    end
    if (!stl) begin
      if (ld) begin
        m_base = a;
        m_cnt  = '0;
        m_kind = ok ? (rd ? K_RD : K_WR) : K_NONE;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
      act++;
      h_kind[act % 8] = m_kind;
      h_addr[act % 8] = ld ? a : {m_base[AW-1:2], burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
      h_ben[act % 8]  = ben;
      src = act - lat;
      if (src > 0 && h_kind[src % 8] == K_WR)
        for (int b = 0; b < NB; b++)
          if (!h_ben[src % 8][b]) ref_mem[h_addr[src % 8]][b*BW +: BW] = wd[b*BW +: BW];
      m_vis = (src > 0 && h_kind[src % 8] == K_RD);
      if (m_vis) m_data = ref_mem[h_addr[src % 8]];
    end
    it.tag  = edge_cnt + 1;
    it.oe   = m_vis && !oe_n && !snooze;
    it.data = m_data;
    it.req  = cur_req;
    sb.push_back(it);
    @(posedge clk);
    #(PERIOD/4 + 1);
  endtask

  task automatic wr1(input logic [AW-1:0] a, input logic [NB-1:0] ben); step(1'b1, 1'b0, a, ben, 1'b1, 1'b0); endtask
  task automatic rd1(input logic [AW-1:0] a); step(1'b1, 1'b1, a, 4'h0, 1'b1, 1'b0); endtask
  task automatic nxt(); step(1'b0, 1'b0, '0, 4'h0, 1'b1, 1'b0); endtask
  task automatic nxt_be(input logic [NB-1:0] ben); step(1'b0, 1'b0, '0, ben, 1'b1, 1'b0); endtask
  task automatic desel(); step(1'b1, 1'($urandom), AW'($urandom), 4'h0, 1'b0, 1'b0); endtask
  task automatic hold1(); step(1'($urandom), 1'($urandom), AW'($urandom), NB'($urandom), 1'b1, 1'b1); endtask
  task automatic drain(); repeat (3) desel(); endtask

  task automatic do_reset(input logic pm);
    @(negedge clk);
    rst = 1'b1; pipe_mode = pm; adv = 1'b0; {sel0_n, sel1, sel2_n} = 3'b110;
    stall = 1'b0; oe_n = 1'b0; snooze = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    lat = pm ? 2 : 1;
    model_clear();
    @(posedge clk);
    #(PERIOD/4 + 1);
    chk(dq_oe === 1'b0, "R12", {dq_oe, dq_out}, '0);
  endtask

  // Mid-cycle output-enable toggle while a read is showing
  task automatic async_oe_check();
    oe_n = 1'b1;
    #1;
    chk(dq_oe === 1'b0, "R9", {dq_oe, dq_out}, '0);
    oe_n = 1'b0;
    #1;
    chk(dq_oe === 1'b1 && dq_out === m_data, "R9", {dq_oe, dq_out}, {1'b1, m_data});
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b1);

    cur_req = "R3";
    wr1(10'h10, 4'h0); wr1(10'h11, 4'h0); wr1(10'h12, 4'h0); wr1(10'h13, 4'h0);

    cur_req = "R1";
    rd1(10'h10); rd1(10'h12); wr1(10'h14, 4'h0); rd1(10'h11);
    wr1(10'h15, 4'h0); rd1(10'h14); rd1(10'h15); rd1(10'h13);
    drain();

    cur_req = "R11";
    wr1(10'h31, 4'h0); wr1(10'h30, 4'h0); rd1(10'h30);
    wr1(10'h31, 4'b1010); rd1(10'h31); rd1(10'h31);
    drain();

    cur_req = "R8";
    wr1(10'h40, 4'h0); wr1(10'h41, 4'h0); wr1(10'h40, 4'b0101);
    wr1(10'h41, 4'hF); desel(); rd1(10'h40); rd1(10'h41);
    drain();

    cur_req = "R6";
    burst_ilv = 1'b1;
    wr1(10'h21, 4'h0); nxt(); nxt(); nxt();
    desel();
    rd1(10'h20); rd1(10'h21); rd1(10'h22); rd1(10'h23);
    rd1(10'h22); nxt(); nxt(); nxt(); nxt();
    drain();
    burst_ilv = 1'b0;
    wr1(10'h25, 4'h0); nxt(); nxt_be(4'b0011); nxt();
    rd1(10'h24); rd1(10'h25); rd1(10'h26); rd1(10'h27);
    rd1(10'h27); nxt(); nxt(); nxt();
    drain();
    burst_ilv = 1'b1;

    cur_req = "R5";
    rd1(10'h21); nxt(); nxt();
    desel(); nxt(); nxt(); nxt();
    drain();

    cur_req = "R4";
    step(1'b1, 1'b1, 10'h10, 4'h0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 10'h11, 4'h0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 10'h12, 4'h0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 10'h10, 4'h0, 1'b0, 1'b0);
    rd1(10'h10); wr1(10'h12, 4'h0); rd1(10'h12);
    drain();

    cur_req = "R7";
    rd1(10'h10); hold1(); hold1(); rd1(10'h11);
    wr1(10'h50, 4'h0); hold1(); rd1(10'h50); hold1(); hold1();
    wr1(10'h21, 4'h0); nxt(); hold1(); nxt(); rd1(10'h22); hold1(); rd1(10'h23);
    drain();

    cur_req = "R9";
    oe_n = 1'b1;
    rd1(10'h10); desel(); desel();
    oe_n = 1'b0;
    rd1(10'h11); desel(); desel();
    async_oe_check();
    drain();

    cur_req = "R10";
    snooze = 1'b1;
    wr1(10'h60, 4'h0); rd1(10'h60); desel(); desel();
    snooze = 1'b0;
    rd1(10'h60);
    drain();

    do_reset(1'b0);

    cur_req = "R2";
    wr1(10'h70, 4'h0); rd1(10'h70); wr1(10'h71, 4'b1100); rd1(10'h71);
    rd1(10'h10); rd1(10'h22); nxt(); nxt(); nxt();
    hold1(); rd1(10'h60);
    drain();

    cur_req = "R3";
    wr1(10'h72, 4'h0); wr1(10'h73, 4'h0); rd1(10'h72); rd1(10'h73);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule